// File: doc/BRIEF.md
# Serial Three-Bit Balance Detector

The block receives a serial stream, one bit per clock, and reports on every cycle how far the most recent three bits lean toward ones or toward zeroes: the number of ones minus the number of zeroes in that window. The result is a signed 3-bit two's-complement value.

Internally a short shift register keeps the window. A purely combinational decoder turns the stored bits into the signed balance. A synchronous clear loads the window with zeroes, which has the same effect as a long run of zero input bits. Because of this the output reads -3 straight after reset, and the zeroes from reset leave the window one at a time as new bits arrive.

Top module: `balance_top`

## Requirements
- R1: On each rising clock edge, with clear low, exactly one bit is taken from `dataIn`. It becomes the newest window bit and appears in `balOut` right after that edge.
- R2: `balOut` equals the number of ones minus the number of zeroes among the three most recently sampled bits.
- R3: `balOut` is 3-bit two's complement, bit 2 the sign. The only values are 3'b101 (-3, no ones), 3'b111 (-1, one one), 3'b001 (+1, two ones) and 3'b011 (+3, three ones).
- R4: After a clock edge with `clrIn` high, the window holds three zeroes, so `balOut` reads 3'b101. The bits that follow enter a window whose older bits are those zeroes.
- R5: When `clrIn` is high, `dataIn` is ignored. A one on `dataIn` during clear still leaves `balOut` at 3'b101.
- R6: Once three newer bits have arrived, the oldest bit is dropped. Three ones followed by one zero give +1, and after two more zeroes the result is -3.
- R7: `balOut` changes only at a clock edge. A change of `dataIn` between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrIn | input | 1 | Synchronous clear, active high; fills the window with zeroes |
| dataIn | input | 1 | Serial data bit sampled each edge |
| balOut | output | 3 | Signed ones-minus-zeroes balance of the last three bits |

## Verification
The stream is driven with all-zero and all-one runs, which reach the two extreme codes, and with alternating bits, which keep the output moving between -1 and +1. A walk through all eight three-bit windows exposes any wrong entry in the decoder. Runs that end in a single changed bit show whether the oldest bit is dropped at the right stage rather than one cycle early or late. Data held high during clear, and data toggled between edges, show that reset has priority and that the output depends only on the register.

// File: rtl/balance_pkg.sv
package balance_pkg;
  localparam int unsigned DefWinLen = 3;

  typedef struct packed {
    logic clear;
    logic shift;
  } winCtl_t;
endpackage

// File: rtl/balance_ctl.sv
module balance_ctl
  import balance_pkg::*;
(
  input  logic    clrIn,
  output winCtl_t ctlOut
);
  always_comb begin
    ctlOut.clear = clrIn;
    ctlOut.shift = !clrIn;
  end
endmodule

// File: rtl/balance_win.sv
module balance_win
  import balance_pkg::*;
#(
  parameter int unsigned WinLen = DefWinLen
) (
  input  logic              clk,
  input  winCtl_t           ctlIn,
  input  logic              dataIn,
  output logic [WinLen-1:0] winOut
);
  logic [WinLen-1:0] winQ;

  always_ff @(posedge clk) begin
    if (ctlIn.clear) begin
      winQ <= '0;
    end else if (ctlIn.shift) begin
      winQ <= {winQ[WinLen-2:0], dataIn};
    end
  end

  assign winOut = winQ;
endmodule

// File: rtl/balance_dec.sv
module balance_dec #(
  parameter int unsigned WinLen = 3,
  parameter int unsigned BalW   = $clog2(WinLen + 1) + 1
) (
  input  logic [WinLen-1:0] winIn,
  output logic [BalW-1:0]   balOut
);
  int onesCnt;

  always_comb begin
    onesCnt = 0;
    for (int i = 0; i < int'(WinLen); i++) begin
      onesCnt = onesCnt + int'(winIn[i]);
    end
    balOut = BalW'(2 * onesCnt - int'(WinLen));
  end
endmodule

// File: rtl/balance_top.sv
module balance_top
  import balance_pkg::*;
#(
  parameter int unsigned WinLen = DefWinLen,
  localparam int unsigned BalW  = $clog2(WinLen + 1) + 1
) (
  input  logic            clk,
  input  logic            clrIn,
  input  logic            dataIn,
  output logic [BalW-1:0] balOut
);
  winCtl_t           winCtl;
  logic [WinLen-1:0] winBits;

  balance_ctl uCtl (
    .clrIn (clrIn),
    .ctlOut(winCtl)
  );

  balance_win #(.WinLen(WinLen)) uWin (
    .clk   (clk),
    .ctlIn (winCtl),
    .dataIn(dataIn),
    .winOut(winBits)
  );

  balance_dec #(.WinLen(WinLen), .BalW(BalW)) uDec (
    .winIn (winBits),
    .balOut(balOut)
  );
endmodule

// File: rtl/balance_chk.sv
module balance_chk #(
  parameter int unsigned BalW = 3
) (
  input logic            clk,
  input logic            clrIn,
  input logic            dataIn,
  input logic [BalW-1:0] balOut
);
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (clrIn)
    (balOut == 3'b101 || balOut == 3'b111 || balOut == 3'b001 || balOut == 3'b011)); // R3

  AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (clrIn)
    $past(clrIn) |-> balOut == 3'b101); // R4

  AST_ONE_NO_DROP: assert property (@(posedge clk) disable iff (clrIn)
    dataIn |=> $signed(balOut) >= $signed($past(balOut))); // R1

  AST_ZERO_NO_RISE: assert property (@(posedge clk) disable iff (clrIn)
    !dataIn |=> $signed(balOut) <= $signed($past(balOut))); // R2
endmodule

bind balance_top balance_chk #(.BalW(BalW)) uChk (
  .clk   (clk),
  .clrIn (clrIn),
  .dataIn(dataIn),
  .balOut(balOut)
);

// File: tb/sim_balance_top.sv
module sim_balance_top;
  logic       clk = 1'b0;
  logic       clrIn = 1'b1;
  logic       dataIn = 1'b0;
  logic [2:0] balOut;

  int nCmp = 0;
  int nBad = 0;
  bit refQ[$];

  balance_top u0 (.clk(clk), .clrIn(clrIn), .dataIn(dataIn), .balOut(balOut));

  always #2 clk = ~clk;

  function automatic logic [2:0] expBal();
    int ones = 0;
    foreach (refQ[i]) ones += int'(refQ[i]);
    return 3'(2 * ones - 3);
  endfunction

  task automatic check(input logic [2:0] exp, input string req);
    nCmp++;
    if (balOut !== exp) begin
      nBad++;
      $display("FAIL %s: balOut=%b expected=%b at %0t", req, balOut, exp, $time);
    end
  endtask

  // one clock with the given inputs, then update the model and compare
  task automatic step(input bit b, input bit clr, input string req);
    @(negedge clk);
    dataIn = b;
    clrIn = clr;
    @(posedge clk);
    #1;
    if (clr) refQ = '{0, 0, 0};
    else begin
      refQ.push_front(b);
      void'(refQ.pop_back());
    end
    check(expBal(), req);
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog: balOut=%b expected=finish", balOut);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    refQ = '{0, 0, 0};
    // R4: clear gives -3
    step(0, 1, "R4");
    check(3'b101, "R4");
    // R5: data high during clear is ignored
    step(1, 1, "R5");
    step(1, 1, "R5");
    check(3'b101, "R5");
    // R1/R6: ones ramp in after clear, then the oldest bits drop out
    step(1, 0, "R1");
    check(3'b111, "R1");
    step(1, 0, "R1");
    check(3'b001, "R1");
    step(1, 0, "R3");
    check(3'b011, "R3");
    step(0, 0, "R6");
    check(3'b001, "R6");
    step(0, 0, "R6");
    step(0, 0, "R6");
    check(3'b101, "R6");
    // R7: mid-cycle input change has no effect before the edge
    @(negedge clk);
    dataIn = 1'b1;
    #1;
    check(3'b101, "R7");
    dataIn = 1'b0;
    #0.5;
    check(3'b101, "R7");
    // R2: alternating pattern
    for (int i = 0; i < 10; i++) step(bit'(i % 2), 0, "R2");
    // R2/R3: every window value from a 3-bit counter pattern
    for (int v = 0; v < 8; v++) begin
      for (int k = 2; k >= 0; k--) step(bit'((v >> k) & 1), 0, "R2");
    end
    // R4: clear in the middle of a run of ones
    step(1, 0, "R4");
    step(1, 1, "R4");
    check(3'b101, "R4");
    step(1, 0, "R4");
    check(3'b111, "R4");
    // R2: pseudo-random tail
    for (int i = 0; i < 64; i++) step(bit'((i * 37 + 11) % 7 < 3), 0, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule